// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a two-part logical address, a segment number and an offset, into a physical address. It looks the address up in a small table held on chip. Each of the eight table entries describes one contiguous physical region. An entry holds a valid flag, a base physical address, a length limit and three permission bits (read, write, execute). System software fills the table through a write port. That port takes effect only while the privilege input is high.

Each translate request indexes the table by its segment number. The block then checks the entry's valid flag, compares the offset with the entry's limit and tests the access type against the entry's permissions. When every check passes, it adds the base to the offset. The result appears one clock after the request as either a physical address or a fault code. A two-state machine drives the result port. ST_IDLE means no result is presented. ST_RESP means a result is presented. The machine goes from ST_IDLE to ST_RESP on a request and stays in ST_RESP while requests arrive back to back. It returns from ST_RESP to ST_IDLE in any cycle without a request, and it stays in ST_IDLE while no requests arrive.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, rsp_valid is 0 and every table entry is invalid, so any translation returns fault code 1 until a privileged write marks its entry valid.
- R2: A request with req_valid high in cycle t gives rsp_valid high in cycle t+1. A cycle without a request gives rsp_valid low in the next cycle.
- R3: When all checks pass, rsp_fault is 0 and rsp_paddr equals the selected base plus the zero-extended offset, truncated to PA_W bits.
- R4: Selecting an entry whose valid flag is clear gives rsp_fault = 1 (invalid segment). This has the highest priority.
- R5: For a valid entry, an offset greater than or equal to the entry's limit gives rsp_fault = 2 (bound). A limit of 0 faults every offset.
- R6: For a valid, in-bound request, an access not allowed by the entry gives rsp_fault = 3 (permission). The access codes are read = 0, write = 1 and execute = 2. These test permission bit 0, 1 and 2 respectively. Access code 3 always gives fault 3.
- R7: A table write with wr_priv low changes no entry.
- R8: A translation issued in the same cycle as a write to its entry uses the old contents of that entry. The new contents apply from the next cycle.
- R9: A privileged write changes only the entry selected by wr_idx.
- R10: rsp_paddr is 0 whenever rsp_fault is nonzero or rsp_valid is low, and rsp_fault is 0 whenever rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translate request strobe |
| req_seg | input | 3 | Segment number |
| req_off | input | 12 | Offset within segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| wr_en | input | 1 | Table write strobe |
| wr_priv | input | 1 | Privilege qualifier for table writes |
| wr_idx | input | 3 | Entry index to write |
| wr_valid | input | 1 | Valid flag written to the entry |
| wr_base | input | 16 | Base physical address written |
| wr_limit | input | 13 | Segment length written |
| wr_perm | input | 3 | Permissions written: bit 0 read, bit 1 write, bit 2 execute |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | 16 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 invalid segment, 2 bound, 3 permission |

## Verification
A corrupted table entry shows up on the first translation that selects it, one cycle after the request, as a wrong address or a wrong fault code. A stray write to a neighbouring entry shows up the next time that neighbour is translated. Because of that, the random traffic revisits every segment many times. A stuck state in the result machine shows as rsp_valid wrong in the cycle right after a request or an idle cycle. An unprivileged write that leaks through shows as a changed result on the next translation of that entry.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_INVAL = 2'd1,
        FLT_BOUND = 2'd2,
        FLT_PERM  = 2'd3
    } fault_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    localparam int PERM_W = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_priv,
    input  logic [SEG_W-1:0]              wr_idx,
    input  logic                          wr_valid,
    input  logic [PA_W-1:0]               wr_base,
    input  logic [OFF_W:0]                wr_limit,
    input  logic [seg_xlate_pkg::PERM_W-1:0] wr_perm,
    input  logic [SEG_W-1:0]              rd_idx,
    output logic                          rd_valid,
    output logic [PA_W-1:0]               rd_base,
    output logic [OFF_W:0]                rd_limit,
    output logic [seg_xlate_pkg::PERM_W-1:0] rd_perm,
    output logic [(1<<SEG_W)-1:0]         valid_vec
);
    localparam int N_ENT = 1 << SEG_W;

    logic [PA_W-1:0]                   base_q  [N_ENT];
    logic [OFF_W:0]                    limit_q [N_ENT];
    logic [seg_xlate_pkg::PERM_W-1:0]  perm_q  [N_ENT];
    logic [N_ENT-1:0]                  valid_q;
    logic                              wr_ok;

    assign wr_ok = wr_en && wr_priv;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic hit;
        assign hit = wr_ok && (wr_idx == SEG_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                perm_q[g]  <= '0;
            end else if (hit) begin
                valid_q[g] <= wr_valid;
                base_q[g]  <= wr_base;
                limit_q[g] <= wr_limit;
                perm_q[g]  <= wr_perm;
            end
        end
    end

    assign rd_valid  = valid_q[rd_idx];
    assign rd_base   = base_q[rd_idx];
    assign rd_limit  = limit_q[rd_idx];
    assign rd_perm   = perm_q[rd_idx];
    assign valid_vec = valid_q;

endmodule

// File: rtl/seg_check.sv
module seg_check #(
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic                             ent_valid,
    input  logic [PA_W-1:0]                  ent_base,
    input  logic [OFF_W:0]                   ent_limit,
    input  logic [seg_xlate_pkg::PERM_W-1:0] ent_perm,
    input  logic [OFF_W-1:0]                 off,
    input  seg_xlate_pkg::acc_e              acc,
    output seg_xlate_pkg::fault_e            fault,
    output logic [PA_W-1:0]                  paddr
);
    import seg_xlate_pkg::*;

    logic allowed;
    logic in_bound;

    always_comb begin
        unique case (acc)
            ACC_READ:  allowed = ent_perm[0];
            ACC_WRITE: allowed = ent_perm[1];
            ACC_EXEC:  allowed = ent_perm[2];
            default:   allowed = 1'b0;
        endcase
    end

    assign in_bound = {1'b0, off} < ent_limit;

    always_comb begin
        fault = FLT_NONE;
        paddr = '0;
        if (!ent_valid) begin
            fault = FLT_INVAL;
        end else if (!in_bound) begin
            fault = FLT_BOUND;
        end else if (!allowed) begin
            fault = FLT_PERM;
        end else begin
            paddr = ent_base + {{(PA_W-OFF_W){1'b0}}, off};
        end
    end

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [1:0]       req_acc,
    input  logic             wr_en,
    input  logic             wr_priv,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [OFF_W:0]   wr_limit,
    input  logic [2:0]       wr_perm,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault
);
    import seg_xlate_pkg::*;

    logic                 sel_valid;
    logic [PA_W-1:0]      sel_base;
    logic [OFF_W:0]       sel_limit;
    logic [PERM_W-1:0]    sel_perm;
    logic [(1<<SEG_W)-1:0] tbl_valid;
    fault_e               chk_fault;
    logic [PA_W-1:0]      chk_paddr;

    rsp_state_e           state_q, state_d;
    logic [PA_W-1:0]      paddr_q;
    fault_e               fault_q;

    seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_priv   (wr_priv),
        .wr_idx    (wr_idx),
        .wr_valid  (wr_valid),
        .wr_base   (wr_base),
        .wr_limit  (wr_limit),
        .wr_perm   (wr_perm),
        .rd_idx    (req_seg),
        .rd_valid  (sel_valid),
        .rd_base   (sel_base),
        .rd_limit  (sel_limit),
        .rd_perm   (sel_perm),
        .valid_vec (tbl_valid)
    );

    seg_check #(.OFF_W(OFF_W), .PA_W(PA_W)) check_i (
        .ent_valid (sel_valid),
        .ent_base  (sel_base),
        .ent_limit (sel_limit),
        .ent_perm  (sel_perm),
        .off       (req_off),
        .acc       (acc_e'(req_acc)),
        .fault     (chk_fault),
        .paddr     (chk_paddr)
    );

    // next-state decision
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result payload registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else begin
            unique case (state_d)
                ST_RESP: begin
                    paddr_q <= chk_paddr;
                    fault_q <= chk_fault;
                end
                default: begin
                    paddr_q <= '0;
                    fault_q <= FLT_NONE;
                end
            endcase
        end
    end

    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_paddr = paddr_q;
    assign rsp_fault = fault_q;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int SEG_W = 3,
    parameter int OFF_W = 12,
    parameter int PA_W  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [OFF_W-1:0]      req_off,
    input logic                  wr_en,
    input logic                  wr_priv,
    input logic                  rsp_valid,
    input logic [PA_W-1:0]       rsp_paddr,
    input logic [1:0]            rsp_fault,
    input logic [PA_W-1:0]       sel_base,
    input logic [OFF_W:0]        sel_limit,
    input logic [(1<<SEG_W)-1:0] tbl_valid
);

    a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_idle_follows_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_paddr == '0 && rsp_fault == 2'd0));

    a_r10_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == '0);

    a_r3_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd0) |->
            rsp_paddr == PA_W'($past(sel_base) + {{(PA_W-OFF_W){1'b0}}, $past(req_off)}));

    a_r5_bound_is_real: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd2) |-> {1'b0, $past(req_off)} >= $past(sel_limit));

    a_r7_unpriv_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_priv) |=> $stable(tbl_valid));

endmodule

bind seg_xlate_top seg_xlate_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_off   (req_off),
    .wr_en     (wr_en),
    .wr_priv   (wr_priv),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .sel_base  (sel_base),
    .sel_limit (sel_limit),
    .tbl_valid (tbl_valid)
);

// File: tb/seg_xlate_top_tb_top.sv
module seg_xlate_top_tb_top;

    localparam int SEG_W = 3;
    localparam int OFF_W = 12;
    localparam int PA_W  = 16;
    localparam int N_ENT = 1 << SEG_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic [1:0]       req_acc = '0;
    logic             wr_en = 1'b0;
    logic             wr_priv = 1'b0;
    logic [SEG_W-1:0] wr_idx = '0;
    logic             wr_valid = 1'b0;
    logic [PA_W-1:0]  wr_base = '0;
    logic [OFF_W:0]   wr_limit = '0;
    logic [2:0]       wr_perm = '0;
    logic             rsp_valid;
    logic [PA_W-1:0]  rsp_paddr;
    logic [1:0]       rsp_fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic            m_valid [N_ENT];
    logic [PA_W-1:0] m_base  [N_ENT];
    logic [OFF_W:0]  m_limit [N_ENT];
    logic [2:0]      m_perm  [N_ENT];

    always #5 clk = ~clk;

    seg_xlate_top #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .wr_en(wr_en), .wr_priv(wr_priv), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_base(wr_base), .wr_limit(wr_limit), .wr_perm(wr_perm),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    function automatic logic [1:0] exp_fault(int s, logic [OFF_W-1:0] o, logic [1:0] a);
        logic ok;
        if (!m_valid[s]) return 2'd1;
        if ({1'b0, o} >= m_limit[s]) return 2'd2;
        case (a)
            2'd0: ok = m_perm[s][0];
            2'd1: ok = m_perm[s][1];
            2'd2: ok = m_perm[s][2];
            default: ok = 1'b0;
        endcase
        return ok ? 2'd0 : 2'd3;
    endfunction

    function automatic logic [PA_W-1:0] exp_addr(int s, logic [OFF_W-1:0] o, logic [1:0] a);
        if (exp_fault(s, o, a) != 2'd0) return '0;
        return m_base[s] + {{(PA_W-OFF_W){1'b0}}, o};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tbl_write(int idx, logic pv, logic v, logic [PA_W-1:0] b,
                             logic [OFF_W:0] l, logic [2:0] p);
        wr_en = 1'b1; wr_priv = pv; wr_idx = SEG_W'(idx);
        wr_valid = v; wr_base = b; wr_limit = l; wr_perm = p;
        @(negedge clk);
        wr_en = 1'b0; wr_priv = 1'b0;
        if (pv) begin
            m_valid[idx] = v; m_base[idx] = b; m_limit[idx] = l; m_perm[idx] = p;
        end
    endtask

    task automatic xlate(string req, int s, logic [OFF_W-1:0] o, logic [1:0] a);
        logic [1:0]      ef;
        logic [PA_W-1:0] ea;
        ef = exp_fault(s, o, a);
        ea = exp_addr(s, o, a);
        req_valid = 1'b1; req_seg = SEG_W'(s); req_off = o; req_acc = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " fault"}, 32'(rsp_fault), 32'(ef));
        check({req, " paddr"}, 32'(rsp_paddr), 32'(ea));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [1:0]      ef;
        logic [PA_W-1:0] ea;
        void'($urandom(32'h5EC7_0A11));
        for (int i = 0; i < N_ENT; i++) begin
            m_valid[i] = 1'b0; m_base[i] = '0; m_limit[i] = '0; m_perm[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        for (int i = 0; i < N_ENT; i++) xlate("R1 entry invalid at reset", i, 12'd0, 2'd0);

        // R2: idle cycle drops rsp_valid; R10 zeros
        @(negedge clk);
        check("R2 idle rsp_valid", 32'(rsp_valid), 32'd0);
        check("R10 idle fault", 32'(rsp_fault), 32'd0);
        check("R10 idle paddr", 32'(rsp_paddr), 32'd0);

        // R3: basic translation
        tbl_write(1, 1'b1, 1'b1, 16'h4000, 13'd256, 3'b011);
        xlate("R3 read in bound", 1, 12'd0, 2'd0);
        xlate("R3 write last byte", 1, 12'd255, 2'd1);
        check("R3 last byte addr", 32'(rsp_paddr), 32'h40FF);
        tbl_write(7, 1'b1, 1'b1, 16'hFFF0, 13'd4096, 3'b111);
        xlate("R3 wraparound sum", 7, 12'h020, 2'd2);
        check("R3 wrap addr", 32'(rsp_paddr), 32'h0010);

        // R5: bound
        xlate("R5 offset equals limit", 1, 12'd256, 2'd0);
        tbl_write(3, 1'b1, 1'b1, 16'h1000, 13'd0, 3'b111);
        xlate("R5 zero limit", 3, 12'd0, 2'd0);
        xlate("R5 over bound beats perm", 1, 12'd300, 2'd2);

        // R6: permissions
        xlate("R6 exec denied", 1, 12'd4, 2'd2);
        xlate("R6 reserved access", 7, 12'd4, 2'd3);
        tbl_write(2, 1'b1, 1'b1, 16'h2000, 13'd64, 3'b100);
        xlate("R6 code segment read denied", 2, 12'd1, 2'd0);
        xlate("R6 code segment write denied", 2, 12'd1, 2'd1);
        xlate("R6 code segment exec ok", 2, 12'd1, 2'd2);

        // R4: invalid beats bound and perm
        xlate("R4 invalid entry", 5, 12'hFFF, 2'd3);
        tbl_write(3, 1'b1, 1'b0, 16'h1000, 13'd100, 3'b111);
        xlate("R4 invalidated entry", 3, 12'd1, 2'd0);

        // R7: unprivileged write ignored
        tbl_write(1, 1'b0, 1'b1, 16'h9999, 13'd4096, 3'b111);
        xlate("R7 unpriv write ignored", 1, 12'd10, 2'd2);
        tbl_write(5, 1'b0, 1'b1, 16'h9999, 13'd4096, 3'b111);
        xlate("R7 unpriv cannot validate", 5, 12'd10, 2'd0);

        // R8: same-cycle write and translate
        ef = exp_fault(2, 12'd5, 2'd2);
        ea = exp_addr(2, 12'd5, 2'd2);
        wr_en = 1'b1; wr_priv = 1'b1; wr_idx = 3'd2; wr_valid = 1'b1;
        wr_base = 16'h3000; wr_limit = 13'd64; wr_perm = 3'b100;
        req_valid = 1'b1; req_seg = 3'd2; req_off = 12'd5; req_acc = 2'd2;
        @(negedge clk);
        wr_en = 1'b0; wr_priv = 1'b0; req_valid = 1'b0;
        m_base[2] = 16'h3000;
        check("R8 same cycle sees old fault", 32'(rsp_fault), 32'(ef));
        check("R8 same cycle sees old base", 32'(rsp_paddr), 32'(ea));
        xlate("R8 next cycle sees new base", 2, 12'd5, 2'd2);
        check("R8 new base addr", 32'(rsp_paddr), 32'h3005);

        // R9: random traffic with mixed writes
        for (int k = 0; k < 600; k++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r < 2) begin
                tbl_write(int'($urandom_range(0, N_ENT-1)), 1'($urandom_range(0, 1)),
                          1'($urandom_range(0, 3) != 0), 16'($urandom()),
                          13'($urandom_range(0, 4096)), 3'($urandom()));
            end else if (r == 2) begin
                @(negedge clk);
                check("R2 random idle", 32'(rsp_valid), 32'd0);
            end else begin
                xlate("R9 random translate", int'($urandom_range(0, N_ENT-1)),
                      12'($urandom()), 2'($urandom()));
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule